// File: doc/BRIEF.md
# Double-Precision to Signed 64-bit Integer Converter

This unit turns one IEEE 754 binary64 operand into a signed 64-bit two's complement integer, rounded under a rounding mode chosen per operation. Each conversion also produces two exception indications: one marks an operand that has no representable integer result, the other marks a result that differs from the exact value. Operands with a zero exponent field, subnormals included, are flushed to zero before conversion.

Internally a control part classifies the operand and picks the alignment, and a datapath part shifts the significand, rounds, saturates and applies the sign. The result, both flags and a valid strobe are registered, so each accepted operand gives exactly one result on the following clock. Flags belong to a single operation and are never accumulated.

Top module: `dbl2int_conv`

## Requirements
- R1: An operand presented with `inValid` high gives `outValid` high with its result and flags on the next rising clock edge. With `inValid` low, `outValid` is low on the next edge. `outValid`, `result` and both flags are 0 during and right after reset.
- R2: A NaN operand (exponent field bits 62:52 all ones, fraction bits 51:0 nonzero) of either sign gives `result` = 0x7FFF_FFFF_FFFF_FFFF and raises `flagInvalid`.
- R3: An infinite operand (exponent field all ones, fraction zero) raises `flagInvalid` and gives 0x7FFF_FFFF_FFFF_FFFF when bit 63 is 0 and 0x8000_0000_0000_0000 when bit 63 is 1.
- R4: An operand whose exponent field is zero (signed zero or subnormal) gives 0 with neither flag raised.
- R5: With an unbiased exponent (field minus 1023) of 63 or more, the result saturates by sign with `flagInvalid`, except that exponent 63, sign 1 and zero fraction gives 0x8000_0000_0000_0000 with no flag.
- R6: With an unbiased exponent from 52 to 62, the result is the significand (hidden bit included) shifted left by exponent minus 52, with no flag.
- R7: `rndMode` = 0 rounds to nearest with ties going to the even integer.
- R8: `rndMode` = 1 truncates toward zero.
- R9: `rndMode` = 2 rounds toward plus infinity and `rndMode` = 3 toward minus infinity.
- R10: `flagInexact` is raised exactly when discarded fraction bits are nonzero and the operand is otherwise valid; an unbiased exponent below -1 gives a magnitude of 0 before rounding with the discarded part below one half and nonzero.
- R11: A negative operand yields the two's complement negation of its rounded magnitude.
- R12: `flagInvalid` and `flagInexact` are never raised together; a magnitude reaching bit 63 after rounding is reported as invalid and saturated by sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand and mode are presented this cycle |
| operand | input | 64 | binary64 operand |
| rndMode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| outValid | output | 1 | Result and flags belong to the operand of the previous cycle |
| result | output | 64 | Signed integer result |
| flagInvalid | output | 1 | No representable result; output saturated |
| flagInexact | output | 1 | Result differs from the exact value |

## Verification
The sweep walks every unbiased exponent from -70 to 66 in both signs and all four modes, with fractions that put the discarded part exactly at one half, just above and below it, and at zero, so a design that breaks ties away from zero or ignores the sticky bit returns an integer one off from the expected value. Exponent -1 and -2 separate the round bit from the clamped tiny path; a wrong shift clamp would lose the round bit of values between one half and one. The exponent-63 edge checks that only the exact negative power of two escapes saturation, and a design that applied the escape to any fraction or sign would return an unflagged wrong value. Specials confirm that NaN sign is ignored while infinity sign is not, and that subnormals produce no inexact flag.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;
  localparam int FRAC_W = 52;
  localparam int EXP_W  = 11;
  localparam int INT_W  = 64;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int EU_W   = EXP_W + 2;
  localparam int SH_W   = $clog2(INT_W);
  localparam int RCLAMP = FRAC_W + 2;
  localparam int EXT_W  = SIG_W + RCLAMP;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rndMode_e;

  typedef struct packed {
    logic            load;
    logic            saturate;
    logic            satNeg;
    logic            forceZero;
    logic            forceMinNeg;
    logic            leftAlign;
    logic [SH_W-1:0] shiftAmt;
  } ctrlStrobe_t;
endpackage

// File: rtl/dbl2int_ctrl.sv
module dbl2int_ctrl
  import dbl2int_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              signBit,
  input  logic [EXP_W-1:0]  expField,
  input  logic [FRAC_W-1:0] fracField,
  output ctrlStrobe_t       strobe,
  output logic              outValid
);
  logic signed [EU_W-1:0] eUnb;
  logic expAllOnes, expAllZero, fracZero;
  logic isNan, isInf, isBig, isMinNeg, leftAl, clampR;

  assign eUnb       = $signed({2'b00, expField}) - EU_W'(BIAS);
  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;
  assign fracZero   = ~|fracField;

  assign isNan    = expAllOnes & ~fracZero;
  assign isInf    = expAllOnes & fracZero;
  assign isBig    = ~expAllOnes & ~expAllZero & (eUnb >= EU_W'(INT_W - 1));
  assign isMinNeg = isBig & (eUnb == EU_W'(INT_W - 1)) & signBit & fracZero;
  assign leftAl   = eUnb >= EU_W'(FRAC_W);
  assign clampR   = eUnb < -EU_W'(1);

  always_comb begin
    strobe.load        = inValid;
    strobe.saturate    = isNan | isInf | (isBig & ~isMinNeg);
    strobe.satNeg      = signBit & ~isNan;
    strobe.forceZero   = expAllZero;
    strobe.forceMinNeg = isMinNeg;
    strobe.leftAlign   = leftAl;
    if (leftAl)
      strobe.shiftAmt = SH_W'(eUnb - EU_W'(FRAC_W));
    else if (clampR)
      strobe.shiftAmt = SH_W'(RCLAMP);
    else
      strobe.shiftAmt = SH_W'(EU_W'(FRAC_W) - eUnb);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/dbl2int_dpath.sv
module dbl2int_dpath
  import dbl2int_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              signBit,
  input  logic [FRAC_W-1:0] fracField,
  input  logic [1:0]        rndMode,
  output logic [INT_W-1:0]  result,
  output logic              flagInvalid,
  output logic              flagInexact
);
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  logic [SIG_W-1:0] sig;
  logic [INT_W-1:0] magL, magR, magPre, magRnd;
  logic [EXT_W-1:0] ext;
  logic rndBit, stkBit, lsbOdd, incr, ovf;
  logic [INT_W-1:0] nxtResult;
  logic nxtInv, nxtInx;

  assign sig  = {1'b1, fracField};
  assign magL = INT_W'(sig) << strobe.shiftAmt;
  assign ext  = {sig, {RCLAMP{1'b0}}} >> strobe.shiftAmt;
  assign magR = INT_W'(ext[EXT_W-1 -: SIG_W]);

  assign magPre = strobe.leftAlign ? magL : magR;
  assign rndBit = ~strobe.leftAlign & ext[RCLAMP-1];
  assign stkBit = ~strobe.leftAlign & (|ext[RCLAMP-2:0]);
  assign lsbOdd = magPre[0];

  always_comb begin
    unique case (rndMode_e'(rndMode))
      RM_NEAR: incr = rndBit & (stkBit | lsbOdd);
      RM_ZERO: incr = 1'b0;
      RM_UP:   incr = (rndBit | stkBit) & ~signBit;
      RM_DOWN: incr = (rndBit | stkBit) & signBit;
      default: incr = 1'b0;
    endcase
  end

  assign magRnd = magPre + INT_W'(incr);
  assign ovf    = magRnd[INT_W-1];

  always_comb begin
    nxtResult = '0;
    nxtInv    = 1'b0;
    nxtInx    = 1'b0;
    if (strobe.forceZero) begin
      nxtResult = '0;
    end else if (strobe.forceMinNeg) begin
      nxtResult = NEG_SAT;
    end else if (strobe.saturate || ovf) begin
      nxtResult = strobe.satNeg ? NEG_SAT : POS_SAT;
      nxtInv    = 1'b1;
    end else begin
      nxtResult = signBit ? -magRnd : magRnd;
      nxtInx    = rndBit | stkBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      flagInvalid <= 1'b0;
      flagInexact <= 1'b0;
    end else if (strobe.load) begin
      result      <= nxtResult;
      flagInvalid <= nxtInv;
      flagInexact <= nxtInx;
    end
  end
endmodule

// File: rtl/dbl2int_conv.sv
module dbl2int_conv
  import dbl2int_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] operand,
  input  logic [1:0]  rndMode,
  output logic        outValid,
  output logic [63:0] result,
  output logic        flagInvalid,
  output logic        flagInexact
);
  ctrlStrobe_t strobe;

  dbl2int_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .signBit   (operand[63]),
    .expField  (operand[62:52]),
    .fracField (operand[51:0]),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  dbl2int_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .signBit     (operand[63]),
    .fracField   (operand[51:0]),
    .rndMode     (rndMode),
    .result      (result),
    .flagInvalid (flagInvalid),
    .flagInexact (flagInexact)
  );
endmodule

// File: rtl/dbl2int_chk.sv
module dbl2int_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [63:0] operand,
  input logic        outValid,
  input logic [63:0] result,
  input logic        flagInvalid,
  input logic        flagInexact
);
  localparam logic [63:0] PMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NMIN = 64'h8000_0000_0000_0000;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid); // R1
  AST_NAN_INDEF: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (&operand[62:52]) && (|operand[51:0])) |=> (flagInvalid && result == PMAX)); // R2
  AST_INF_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (&operand[62:52]) && !(|operand[51:0]))
      |=> (flagInvalid && result == ($past(operand[63]) ? NMIN : PMAX))); // R3
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !(|operand[62:52])) |=> (result == 64'd0 && !flagInvalid && !flagInexact)); // R4
  AST_INVALID_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagInvalid) |-> (result == PMAX || result == NMIN)); // R5
  AST_LEFT_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && operand[62:52] >= 11'd1075 && operand[62:52] <= 11'd1085)
      |=> (!flagInexact && !flagInvalid)); // R6
  AST_NO_DOUBLE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(flagInvalid && flagInexact)); // R12
endmodule

bind dbl2int_conv dbl2int_chk u_chk (.*);

// File: tb/sim_dbl2int_conv.sv
module sim_dbl2int_conv;
  localparam logic [63:0] PMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NMIN = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  rndMode = '0;
  logic        outValid;
  logic [63:0] result;
  logic        flagInvalid, flagInexact;

  int vecCount = 0;
  int missCount = 0;

  always #2 clk = ~clk;

  dbl2int_conv u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand), .rndMode(rndMode),
    .outValid(outValid), .result(result), .flagInvalid(flagInvalid), .flagInexact(flagInexact)
  );

  // Independent model: exact value as fixed point with 128 fraction bits.
  task automatic modelConv(input logic [63:0] op, input logic [1:0] m,
                           output logic [63:0] eRes, output logic eInv, output logic eInx,
                           output string tag);
    logic s;
    logic [10:0] ef;
    logic [51:0] fr;
    int e;
    logic [255:0] fx;
    logic [127:0] ip, fp;
    logic nz, gtHalf, eqHalf, up;
    s = op[63]; ef = op[62:52]; fr = op[51:0];
    e = int'(ef) - 1023;
    eInv = 1'b0; eInx = 1'b0; eRes = '0;
    if (ef == 11'h7FF) begin
      eInv = 1'b1;
      if (fr != 0) begin eRes = PMAX; tag = "R2"; end
      else begin eRes = s ? NMIN : PMAX; tag = "R3"; end
    end else if (ef == 0) begin
      tag = "R4";
    end else if (e >= 63) begin
      tag = "R5";
      if (e == 63 && s && fr == 0) eRes = NMIN;
      else begin eRes = s ? NMIN : PMAX; eInv = 1'b1; end
    end else begin
      if (e < -64) begin
        ip = '0; nz = 1'b1; gtHalf = 1'b0; eqHalf = 1'b0;
      end else begin
        fx = 256'({1'b1, fr}) << (e + 76);
        ip = fx[255:128]; fp = fx[127:0];
        nz = (fp != 0);
        gtHalf = fp > {1'b1, 127'b0};
        eqHalf = fp == {1'b1, 127'b0};
      end
      case (m)
        2'd0:    up = gtHalf | (eqHalf & ip[0]);
        2'd1:    up = 1'b0;
        2'd2:    up = nz & !s;
        default: up = nz & s;
      endcase
      ip = ip + 128'(up);
      if (ip >= (128'd1 << 63)) begin
        eRes = s ? NMIN : PMAX; eInv = 1'b1; tag = "R12";
      end else begin
        eRes = s ? -ip[63:0] : ip[63:0];
        eInx = nz;
        if (e >= 52) tag = "R6";
        else if (e < -1) tag = "R10";
        else if (m == 2'd0) tag = "R7";
        else if (m == 2'd1) tag = "R8";
        else tag = "R9";
        if (s) tag = {tag, "/R11"};
      end
    end
  endtask

  task automatic applyVec(input logic [63:0] op, input logic [1:0] m);
    logic [63:0] eRes;
    logic eInv, eInx;
    string tag;
    modelConv(op, m, eRes, eInv, eInx, tag);
    @(negedge clk);
    operand = op; rndMode = m; inValid = 1'b1;
    @(negedge clk);
    vecCount++;
    if (!outValid || result !== eRes || flagInvalid !== eInv || flagInexact !== eInx) begin
      missCount++;
      $display("FAIL %s op=%h mode=%0d actual v=%b res=%h inv=%b inx=%b expected v=1 res=%h inv=%b inx=%b",
               tag, op, m, outValid, result, flagInvalid, flagInexact, eRes, eInv, eInx);
    end
    if (flagInvalid && flagInexact) begin
      missCount++;
      $display("FAIL R12 op=%h actual both flags set expected at most one", op);
    end
  endtask

  task automatic checkIdle(input string what);
    vecCount++;
    if (outValid !== 1'b0 || result !== 64'd0 || flagInvalid !== 1'b0 || flagInexact !== 1'b0) begin
      missCount++;
      $display("FAIL R1 %s actual v=%b res=%h inv=%b inx=%b expected all zero",
               what, outValid, result, flagInvalid, flagInexact);
    end
  endtask

  initial begin
    logic [51:0] fracs [8];
    repeat (3) @(negedge clk);
    checkIdle("reset state");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("idle after reset");

    // Specials: R2 NaNs of both signs, R3 infinities, R4 zeros and subnormals
    applyVec(64'h7FF8_0000_0000_0000, 2'd0);
    applyVec(64'hFFF0_0000_0000_0001, 2'd2);
    applyVec(64'h7FF0_0000_0000_0000, 2'd1);
    applyVec(64'hFFF0_0000_0000_0000, 2'd3);
    applyVec(64'h0000_0000_0000_0000, 2'd2);
    applyVec(64'h8000_0000_0000_0000, 2'd3);
    applyVec(64'h000F_FFFF_FFFF_FFFF, 2'd2);
    applyVec(64'h8000_0000_0000_0001, 2'd3);
    // R5 corner: -2^63 exact, +2^63 and -(2^63+ulp) saturate
    applyVec(64'hC3E0_0000_0000_0000, 2'd0);
    applyVec(64'h43E0_0000_0000_0000, 2'd0);
    applyVec(64'hC3E0_0000_0000_0001, 2'd1);

    // R1: a dropped valid produces no output strobe
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    vecCount++;
    if (outValid !== 1'b0) begin
      missCount++;
      $display("FAIL R1 idle cycle actual outValid=%b expected 0", outValid);
    end

    fracs[0] = 52'h0;
    fracs[1] = 52'h1;
    fracs[2] = 52'h4_0000_0000_0000;
    fracs[3] = 52'h8_0000_0000_0000;
    fracs[4] = 52'hC_0000_0000_0000;
    fracs[5] = 52'hF_FFFF_FFFF_FFFF;
    fracs[6] = 52'({$urandom, $urandom});
    fracs[7] = 52'({$urandom, $urandom});

    // Sweep R6..R11 across exponents, fractions, signs and modes
    for (int sgn = 0; sgn < 2; sgn++)
      for (int e = -70; e <= 66; e++)
        for (int fi = 0; fi < 8; fi++)
          for (int m = 0; m < 4; m++)
            applyVec({1'(sgn), 11'(e + 1023), fracs[fi]}, 2'(m));

    @(negedge clk);
    inValid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    missCount++;
    $display("FAIL R1 watchdog actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule